// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block drives and observes a parameterized number of general-purpose pins. The pins are grouped into 32-pin banks, and a simple word-addressed register bus controls them. For each pin, a direction bit picks between driving the output data value and leaving the pin as an input. Output bits can be written whole, or changed atomically through write-one set and clear strobe addresses. Every pin level passes through a two-flop synchronizer before software can read it back.

Each pin can flag its rising edge, its falling edge, or both. Separate enable masks select the edges, and these masks are also changed only through set and clear strobes. A detected edge latches a sticky status bit, which software clears by writing a one to it. Every bank splits its status into a low half and a high half of 16 pins, and each half drives its own interrupt line. A global line-enable register gates all of these lines.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: Bank b occupies ten word registers starting at byte address 0x10 + 0x28*b. Their word indices are: 0 direction, 1 output data, 2 output set strobe, 3 output clear strobe, 4 input level, 5 rising-enable set, 6 rising-enable clear, 7 falling-enable set, 8 falling-enable clear, 9 status. The line-enable register sits at 0x08. Address bits 1:0 are ignored. Other addresses read 0, and writes to them change nothing.
- R2: After reset every direction bit is 1 (input), and the output data, both edge-enable masks, status and line-enable are all 0.
- R3: A direction bit of 0 drives the pin: `pin_oe_o` is the inverse of the direction register, which is written directly.
- R4: `pin_o` shows the output data register. A write to index 1 replaces it. A write to index 2 sets the bits that are 1 in the write data, and a write to index 3 clears them; zero bits leave the outputs unchanged. Reads of indices 1, 2 and 3 all return the output data.
- R5: The input level register shows each pin two clock edges after the pin changes, whatever the pin's direction.
- R6: The rising and falling enable masks change only through their set (5, 7) and clear (6, 8) strobes. A read of either strobe of a pair returns that mask.
- R7: A rising edge with the rising enable set, or a falling edge with the falling enable set, makes the pin's status bit 1 on the third clock edge after the pin change. The bit then stays set. Enabling both edges catches both.
- R8: Writing 1 to a status bit clears it; zero bits in the write data leave status unchanged.
- R9: If a new edge and a write-one clear reach the same status bit in the same cycle, the bit stays set.
- R10: `irq_o[2b]` is the OR of bank b status bits 15:0 and `irq_o[2b+1]` is the OR of bits 31:16. Each line is gated by line-enable bit 2b or 2b+1 respectively.
- R11: `rdata_o` is registered. It carries the addressed register one cycle after `rd_i` and is 0 in every other cycle.
- R12: Bit positions at or above `NUM_PINS` in the last bank read as 0 and cannot be set by any write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after `rd_i` |
| pin_i | input | NUM_PINS | Pin levels (asynchronous) |
| pin_o | output | NUM_PINS | Output data to the pads |
| pin_oe_o | output | NUM_PINS | Output enable per pin (1 = drive) |
| irq_o | output | 2*ceil(NUM_PINS/32) | Half-bank interrupt lines |

## Verification
The delicate overlap is a pin edge that reaches the status register in the same cycle as a software write-one clear of that bit. The bench toggles an enabled pin and then issues the clear after a delay that it sweeps over five values, so one sweep point lands exactly on the capture edge. A behavioural reference model, updated every clock from the same stimulus, decides for each delay whether the bit must survive. Set and clear strobes are also mixed with random pin traffic, so the outputs and interrupt lines are compared on every cycle.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  localparam int FIRST_BANK  = 'h10;
  localparam int BANK_STRIDE = 'h28;
  localparam int LINE_EN_OFS = 'h08;
  localparam int BANK_BITS   = 32;
  localparam int HALF_BITS   = 16;

  typedef enum logic [3:0] {
    IDX_DIR   = 4'd0,
    IDX_OUT   = 4'd1,
    IDX_SET   = 4'd2,
    IDX_CLR   = 4'd3,
    IDX_LVL   = 4'd4,
    IDX_RSET  = 4'd5,
    IDX_RCLR  = 4'd6,
    IDX_FSET  = 4'd7,
    IDX_FCLR  = 4'd8,
    IDX_STAT  = 4'd9
  } reg_idx_e;

  function automatic int bank_width(int npins, int bank);
    int rem;
    rem = npins - BANK_BITS * bank;
    return (rem > BANK_BITS) ? BANK_BITS : rem;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);

  logic [W-1:0] meta_q, lvl_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      lvl_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_i;
      lvl_q  <= meta_q;
      prev_q <= lvl_q;
    end
  end

  assign lvl_o  = lvl_q;
  assign rise_o = lvl_q & ~prev_q;
  assign fall_o = ~lvl_q & prev_q;

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_edge_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sel_i,
  input  logic         we_i,
  input  reg_idx_e     idx_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] rise_i,
  input  logic [W-1:0] fall_i,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] out_o,
  output logic [31:0]  rdata_o,
  output logic         irq_lo_o,
  output logic         irq_hi_o
);

  logic [W-1:0] dir_q, out_q, ren_q, fen_q, stat_q;
  logic [W-1:0] hit, w1c, rd_val;
  logic         wr;

  assign wr  = sel_i & we_i;
  assign hit = (rise_i & ren_q) | (fall_i & fen_q);
  assign w1c = (wr && idx_i == IDX_STAT) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '1;
      out_q <= '0;
      ren_q <= '0;
      fen_q <= '0;
    end else if (wr) begin
      case (idx_i)
        IDX_DIR:  dir_q <= wdata_i;
        IDX_OUT:  out_q <= wdata_i;
        IDX_SET:  out_q <= out_q | wdata_i;
        IDX_CLR:  out_q <= out_q & ~wdata_i;
        IDX_RSET: ren_q <= ren_q | wdata_i;
        IDX_RCLR: ren_q <= ren_q & ~wdata_i;
        IDX_FSET: fen_q <= fen_q | wdata_i;
        IDX_FCLR: fen_q <= fen_q & ~wdata_i;
        default:  ;
      endcase
    end
  end

  // new edge takes priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~w1c) | hit;
  end

  always_comb begin
    case (idx_i)
      IDX_DIR:                    rd_val = dir_q;
      IDX_OUT, IDX_SET, IDX_CLR:  rd_val = out_q;
      IDX_LVL:                    rd_val = lvl_i;
      IDX_RSET, IDX_RCLR:         rd_val = ren_q;
      IDX_FSET, IDX_FCLR:         rd_val = fen_q;
      IDX_STAT:                   rd_val = stat_q;
      default:                    rd_val = '0;
    endcase
  end

  assign rdata_o = sel_i ? 32'(rd_val) : '0;
  assign dir_o   = dir_q;
  assign out_o   = out_q;

  generate
    if (W > HALF_BITS) begin : g_two_halves
      assign irq_lo_o = |stat_q[HALF_BITS-1:0];
      assign irq_hi_o = |stat_q[W-1:HALF_BITS];
    end else begin : g_one_half
      assign irq_lo_o = |stat_q;
      assign irq_hi_o = 1'b0;
    end
  endgenerate

  assert_set_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && idx_i == IDX_SET) |=> ((out_q & $past(wdata_i)) == $past(wdata_i)));

  assert_clr_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && idx_i == IDX_CLR) |=> ((out_q & $past(wdata_i)) == '0));

  assert_stat_source_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(hit)) == '0));

  assert_w1c_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(w1c & ~hit)) |=> ((stat_q & $past(w1c & ~hit)) == '0));

  assert_edge_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(w1c & hit)) |=> ((stat_q & $past(w1c & hit)) == $past(w1c & hit)));

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int   NUM_PINS  = 40,
  parameter int   ADDR_W    = 12,
  localparam int  NUM_BANKS = (NUM_PINS + BANK_BITS - 1) / BANK_BITS,
  localparam int  NUM_LINES = 2 * NUM_BANKS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic                 rd_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  input  logic [NUM_PINS-1:0]  pin_i,
  output logic [NUM_PINS-1:0]  pin_o,
  output logic [NUM_PINS-1:0]  pin_oe_o,
  output logic [NUM_LINES-1:0] irq_o
);

  localparam logic [ADDR_W-3:0] LINE_EN_WORD = (ADDR_W-2)'(LINE_EN_OFS >> 2);

  logic [NUM_LINES-1:0] line_en_q;
  logic [NUM_LINES-1:0] line_raw;
  logic [31:0]          bank_rdata [NUM_BANKS];
  logic [31:0]          rdata_d, rdata_q;
  logic                 line_en_hit;

  assign line_en_hit = (addr_i[ADDR_W-1:2] == LINE_EN_WORD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  line_en_q <= '0;
    else if (wr_i && line_en_hit) line_en_q <= wdata_i[NUM_LINES-1:0];
  end

  genvar b;
  generate
    for (b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam int W = bank_width(NUM_PINS, b);
      localparam logic [ADDR_W-1:0] BASE  = ADDR_W'(FIRST_BANK + b * BANK_STRIDE);
      localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(FIRST_BANK + (b + 1) * BANK_STRIDE);

      logic         sel;
      reg_idx_e     idx;
      logic [W-1:0] lvl, rise, fall, dir, outv;

      assign sel = (addr_i >= BASE) && (addr_i < LIMIT);
      assign idx = reg_idx_e'(4'((addr_i - BASE) >> 2));

      gpio_in_sync #(.W(W)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_i  (pin_i[BANK_BITS*b +: W]),
        .lvl_o  (lvl),
        .rise_o (rise),
        .fall_o (fall)
      );

      gpio_bank_regs #(.W(W)) u_regs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .sel_i    (sel),
        .we_i     (wr_i),
        .idx_i    (idx),
        .wdata_i  (wdata_i[W-1:0]),
        .lvl_i    (lvl),
        .rise_i   (rise),
        .fall_i   (fall),
        .dir_o    (dir),
        .out_o    (outv),
        .rdata_o  (bank_rdata[b]),
        .irq_lo_o (line_raw[2*b]),
        .irq_hi_o (line_raw[2*b+1])
      );

      assign pin_o[BANK_BITS*b +: W]    = outv;
      assign pin_oe_o[BANK_BITS*b +: W] = ~dir;
    end
  endgenerate

  assign irq_o = line_raw & line_en_q;

  always_comb begin
    rdata_d = line_en_hit ? 32'(line_en_q) : '0;
    for (int i = 0; i < NUM_BANKS; i++) rdata_d = rdata_d | bank_rdata[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rd_i ? rdata_d : '0;
  end

  assign rdata_o = rdata_q;

  assert_idle_rdata_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> (rdata_o == '0));

endmodule

// File: tb/sim_gpio_edge_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_edge_ctrl;

  localparam int NP = 40;
  localparam int NB = (NP + 31) / 32;
  localparam int NL = 2 * NB;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr = 1'b0, rd = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NP-1:0] pin = '0;
  logic [NP-1:0] pin_o, pin_oe;
  logic [NL-1:0] irq;

  always #2 clk = ~clk;

  gpio_edge_ctrl #(.NUM_PINS(NP), .ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pin), .pin_o(pin_o),
    .pin_oe_o(pin_oe), .irq_o(irq)
  );

  int checks = 0, failures = 0, cycles = 0;
  string phase = "R2";

  // reference model
  bit [31:0] m_dir [NB], m_out [NB], m_ren [NB], m_fen [NB], m_st [NB];
  bit [31:0] m_hit [NB], m_clr [NB];
  bit [NL-1:0] m_ben;
  bit [NP-1:0] m_s1, m_s2, m_pv;
  bit [31:0] m_rd;
  string m_rtag = "R11";

  function automatic bit [31:0] vmask(int b);
    if (32*b + 32 <= NP) return 32'hFFFF_FFFF;
    return (32'h1 << (NP - 32*b)) - 32'h1;
  endfunction

  function automatic bit [31:0] slice(bit [NP-1:0] v, int b);
    bit [NP+31:0] t;
    t = {32'b0, v} >> (32*b);
    return t[31:0];
  endfunction

  function automatic int bank_of(bit [AW-1:0] a);
    for (int b = 0; b < NB; b++)
      if (a >= 16 + 40*b && a < 56 + 40*b) return b;
    return -1;
  endfunction

  function automatic int index_of(bit [AW-1:0] a, int b);
    return (int'(a) - 16 - 40*b) / 4;
  endfunction

  function automatic bit [31:0] model_read(bit [AW-1:0] a, output string tag);
    int b, k;
    tag = "R1";
    if (a[AW-1:2] == 2) return 32'(m_ben);
    b = bank_of(a);
    if (b < 0) return 0;
    k = index_of(a, b);
    case (k)
      0: begin tag = "R3"; return m_dir[b]; end
      1, 2, 3: begin tag = "R4"; return m_out[b]; end
      4: begin tag = "R5"; return slice(m_s2, b) & vmask(b); end
      5, 6: begin tag = "R6"; return m_ren[b]; end
      7, 8: begin tag = "R6"; return m_fen[b]; end
      default: begin tag = "R7"; return m_st[b]; end
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) begin
        m_dir[b] = vmask(b); m_out[b] = 0; m_ren[b] = 0; m_fen[b] = 0; m_st[b] = 0;
      end
      m_ben = 0; m_s1 = 0; m_s2 = 0; m_pv = 0; m_rd = 0; m_rtag = "R11";
    end else begin
      string t;
      int b, k;
      if (rd) begin m_rd = model_read(addr, t); m_rtag = t; end
      else begin m_rd = 0; m_rtag = "R11"; end
      for (int i = 0; i < NB; i++) begin
        m_hit[i] = ((slice(m_s2,i) & ~slice(m_pv,i) & m_ren[i]) |
                    (~slice(m_s2,i) & slice(m_pv,i) & m_fen[i])) & vmask(i);
        m_clr[i] = 0;
      end
      if (wr) begin
        if (addr[AW-1:2] == 2) m_ben = wdata[NL-1:0];
        b = bank_of(addr);
        if (b >= 0) begin
          k = index_of(addr, b);
          case (k)
            0: m_dir[b] = wdata & vmask(b);
            1: m_out[b] = wdata & vmask(b);
            2: m_out[b] = (m_out[b] | wdata) & vmask(b);
            3: m_out[b] = m_out[b] & ~wdata;
            5: m_ren[b] = (m_ren[b] | wdata) & vmask(b);
            6: m_ren[b] = m_ren[b] & ~wdata;
            7: m_fen[b] = (m_fen[b] | wdata) & vmask(b);
            8: m_fen[b] = m_fen[b] & ~wdata;
            9: m_clr[b] = wdata;
            default: ;
          endcase
        end
      end
      for (int i = 0; i < NB; i++) m_st[i] = (m_st[i] & ~m_clr[i]) | m_hit[i];
      m_pv = m_s2; m_s2 = m_s1; m_s1 = pin;
    end
  end

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s (phase %s) actual=%h expected=%h t=%0t", tag, phase, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit [NP-1:0] e_po, e_oe;
    bit [NL-1:0] e_irq;
    for (int i = 0; i < NP; i++) begin
      e_po[i] = m_out[i/32][i%32];
      e_oe[i] = ~m_dir[i/32][i%32];
    end
    for (int l = 0; l < NL; l++)
      e_irq[l] = m_ben[l] & (|((m_st[l/2] >> (16*(l%2))) & 32'hFFFF));
    check(pin_o === e_po, "R4", 64'(pin_o), 64'(e_po));
    check(pin_oe === e_oe, "R3", 64'(pin_oe), 64'(e_oe));
    check(irq === e_irq, "R10", 64'(irq), 64'(e_irq));
    check(rdata === m_rd, m_rtag, 64'(rdata), 64'(m_rd));
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
    cycles++;
    compare();
  endtask

  task automatic bus_wr(int a, bit [31:0] d);
    wr = 1; addr = AW'(a); wdata = d; tick(); wr = 0;
  endtask

  task automatic bus_rd(int a);
    rd = 1; addr = AW'(a); tick(); rd = 0;
  endtask

  function automatic int ra(int b, int k);
    return 16 + 40*b + 4*k;
  endfunction

  task automatic dump_all();
    bus_rd(8);
    for (int b = 0; b < NB; b++)
      for (int k = 0; k < 10; k++) bus_rd(ra(b, k));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    compare();
    phase = "R2"; dump_all();

    phase = "R3";
    bus_wr(ra(0,0), 32'h0000_FFFF);
    bus_wr(ra(1,0), 32'h0000_0000);
    bus_rd(ra(0,0));

    phase = "R4";
    bus_wr(ra(0,1), 32'hA5A5_1234);
    bus_wr(ra(0,2), 32'h00F0_000F);
    bus_wr(ra(0,3), 32'h0000_0003);
    bus_wr(ra(1,2), 32'h0000_0081);
    bus_rd(ra(0,2)); bus_rd(ra(0,3)); bus_rd(ra(1,1));

    phase = "R5";
    pin = 40'hA5_1234_5678; bus_rd(ra(0,4)); bus_rd(ra(0,4)); bus_rd(ra(0,4)); bus_rd(ra(1,4));
    pin = 40'h5A_FFFF_0000; tick(); bus_rd(ra(0,4)); bus_rd(ra(1,4));

    phase = "R6";
    bus_wr(ra(0,5), 32'h0010_00FF);
    bus_wr(ra(0,7), 32'h0000_0FF0);
    bus_wr(ra(0,6), 32'h0000_0003);
    bus_wr(ra(1,5), 32'h0000_00FF);
    bus_rd(ra(0,5)); bus_rd(ra(0,6)); bus_rd(ra(0,8)); bus_rd(ra(1,6));

    phase = "R7";
    bus_wr(8, 4'b0101);
    pin = 40'h00_0000_0000; repeat (4) tick();
    pin = 40'hFF_0010_0FFF; repeat (4) tick();
    bus_rd(ra(0,9)); bus_rd(ra(1,9));
    pin = 40'h00_0000_0000; repeat (4) tick();
    bus_rd(ra(0,9));

    phase = "R10";
    bus_wr(8, 4'b1111); tick(); bus_wr(8, 4'b0010); tick();
    bus_wr(8, 4'b1111);

    phase = "R8";
    bus_wr(ra(0,9), 32'h0000_00F0); bus_rd(ra(0,9));
    bus_wr(ra(0,9), 32'h0000_0000); bus_rd(ra(0,9));
    bus_wr(ra(0,9), 32'hFFFF_FFFF); bus_wr(ra(1,9), 32'hFFFF_FFFF);
    dump_all();

    phase = "R9";
    for (int d = 0; d < 5; d++) begin
      pin[4] = ~pin[4];
      repeat (d) tick();
      bus_wr(ra(0,9), 32'h0000_0010);
      repeat (4) tick();
      bus_rd(ra(0,9));
      bus_wr(ra(0,9), 32'h0000_0010);
    end

    phase = "R12";
    for (int k = 0; k < 9; k++) if (k != 4) bus_wr(ra(1,k), 32'hFFFF_FFFF);
    bus_wr(8, 32'hFFFF_FFFF);
    pin = '1; repeat (4) tick();
    dump_all();

    phase = "R1";
    bus_wr(0, 32'hFFFF_FFFF); bus_wr(4, 32'hFFFF_FFFF); bus_wr(ra(NB,0), 32'h1234_5678);
    bus_wr('h200, 32'hFFFF_FFFF); bus_wr(ra(0,0) + 2, 32'h00FF_00FF);
    bus_rd(0); bus_rd(ra(NB,1)); bus_rd(ra(0,1) + 3);
    dump_all();

    phase = "RAND";
    for (int n = 0; n < 600; n++) begin
      int b, k;
      b = $urandom_range(NB-1); k = $urandom_range(9);
      if ($urandom_range(3) == 0) pin = {$urandom, $urandom};
      case ($urandom_range(3))
        0: bus_wr(ra(b,k), $urandom);
        1: bus_rd(ra(b,k));
        2: bus_wr(8, $urandom);
        default: tick();
      endcase
    end
    dump_all();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule